// File: doc/BRIEF.md
# IrDA Transmit Frame Closing Controller

This block sits between the host's transmit byte queue and the IrDA frame serializer. It holds the bytes to be sent in a 64-entry queue that keeps one extra tag bit per byte. It decides when a frame starts and when it ends, and it hands the serializer one byte per request. The host chooses between two ways of ending a frame. In the first, a 16-bit byte count is programmed in advance. In the second, the host arms a one-shot marker before writing the last byte, and that byte is tagged in the queue.

Transmission can start at once when data is present. Alternatively, a deferred mode holds the frame until the host gives an explicit go. If the queue runs dry before the frame end, the block closes the frame and asks the serializer to send a deliberately broken CRC. It then locks the transmitter until the host flushes the queue and performs a resume access. A configuration bit replaces this abort with stop-bit stretching while the queue is empty.

Every serializer-facing output is registered. A byte taken in a cycle where `ser_ready` is high appears on `out_data` with `out_valid` in the next cycle. `frame_done` follows one cycle after the frame closes.

Top module: `irtx_frame_closer`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_last`, `out_abort`, `out_stretch` and `frame_done` are all low.
- R2: With `cfg_tag_mode`=0, the frame length comes from two byte writes through `len_byte`. `len_lo_we` loads bits 7:0 and `len_hi_we` loads bits 15:8. The length is captured when the frame starts, and the frame ends on the byte whose 1-based position equals that length.
- R3: `out_last` is high only together with `out_valid`, and only on the final byte of a frame.
- R4: With `cfg_tag_mode`=1, a byte accepted after an `eot_set` pulse carries a tag, and the frame ends on that byte. The programmed length is ignored in this mode.
- R5: The end-of-transmission marker tags exactly one accepted write and then clears, so later writes are untagged. A write in the same cycle as `eot_set` is not tagged.
- R6: With `cfg_deferred`=0, a frame starts as soon as the queue holds data. With `cfg_deferred`=1, no byte leaves until a `go_set` pulse. The go request clears when the frame starts, so the next frame needs a new pulse.
- R7: With `cfg_urun_off`=0, a `ser_ready` cycle inside a frame with an empty queue yields one `out_abort` pulse with no data. This closes the frame with a corrupt CRC and locks the transmitter.
- R8: While locked, no data leaves and `resume_rd` alone has no effect. A `fifo_clr` pulse followed later by a `resume_rd` pulse unlocks the transmitter, and the bytes queued before the flush are discarded.
- R9: With `cfg_urun_off`=1, a `ser_ready` cycle with an empty queue inside a frame yields an `out_stretch` pulse instead of an abort. The frame continues when data arrives.
- R10: The queue holds 64 bytes. Writes while it is full are ignored, and bytes leave in write order.
- R11: `frame_done` pulses one cycle after each `out_last` or `out_abort` pulse.
- R12: At most one of `out_valid`, `out_abort` and `out_stretch` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tag_mode | input | 1 | 0: programmed length ends the frame; 1: tagged byte ends the frame |
| cfg_deferred | input | 1 | 1: hold each frame until `go_set` |
| cfg_urun_off | input | 1 | 1: stretch the stop bit instead of aborting on an empty queue |
| len_lo_we | input | 1 | Load `len_byte` into length bits 7:0 |
| len_hi_we | input | 1 | Load `len_byte` into length bits 15:8 |
| len_byte | input | 8 | Length byte value |
| eot_set | input | 1 | Arm the tag for the next accepted write |
| go_set | input | 1 | Deferred start request |
| fifo_clr | input | 1 | Flush the transmit queue |
| resume_rd | input | 1 | Resume access that releases the underrun lock |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Queue write byte |
| ser_ready | input | 1 | Serializer asks for the next byte slot |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_data | output | 8 | Byte to serialize |
| out_last | output | 1 | This byte ends the frame; end flags follow with a good CRC |
| out_abort | output | 1 | Close the frame now with end flags and a wrong CRC |
| out_stretch | output | 1 | Extend the stop bit for this slot |
| frame_done | output | 1 | One-cycle pulse after a frame close |

## Verification
A stuck or misplaced byte counter shows up as `out_last` on the wrong byte within the same frame. A tag marker that does not clear shows up as an extra one-byte frame one slot later. A lock flag that releases too early lets queued bytes reach `out_data` within a few cycles of the illegal resume. A lost deferred request shows as bytes appearing without `go_set`, or as silence after it, within the first handful of slots. Queue pointer faults reorder or drop bytes, which the byte-by-byte comparison of every frame exposes at the first affected position.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 16;

    // one queue entry: payload plus the end-of-frame tag
    typedef struct packed {
        logic              tag;
        logic [BYTE_W-1:0] data;
    } txent_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SEND = 2'd1,
        S_LOCK = 2'd2
    } seq_st_t;

    // decide whether the byte being taken closes the frame
    function automatic logic is_final(input logic tag_mode,
                                      input logic tag,
                                      input logic [LEN_W-1:0] next_cnt,
                                      input logic [LEN_W-1:0] frame_len);
        return tag_mode ? tag : (next_cnt == frame_len);
    endfunction

endpackage

// File: rtl/irtx_tag_fifo.sv
module irtx_tag_fifo
    import irtx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   push,
    input  txent_t wdata,
    input  logic   pop,
    output txent_t rdata,
    output logic   empty,
    output logic   full
);
    // DEPTH must be a power of two so the pointers wrap on their own
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    txent_t         mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CW-1:0]  cnt;
    logic           push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R10: occupancy never exceeds the depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R10: a write into a full queue without a read leaves it full
    a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/irtx_host_ctl.sv
module irtx_host_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cfg_deferred,
    input  logic go_set,
    input  logic eot_set,
    input  logic wr_en,
    input  logic fifo_full,
    input  logic fifo_clr,
    input  logic fifo_empty,
    input  logic start_fire,
    output logic start_ok,
    output logic tag_bit
);
    logic go_q;
    logic eot_q;
    logic accepted;

    assign accepted = wr_en && !fifo_full && !fifo_clr;
    assign tag_bit  = eot_q;
    assign start_ok = !fifo_empty && (!cfg_deferred || go_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q  <= 1'b0;
            eot_q <= 1'b0;
        end else begin
            go_q  <= go_set  | (go_q  & ~start_fire);
            eot_q <= eot_set | (eot_q & ~accepted);
        end
    end

    // R5: the marker is consumed by one accepted write
    a_r5_eot_clears: assert property (@(posedge clk) disable iff (rst)
        (eot_q && accepted && !eot_set) |=> !eot_q);

    // R6: a frame start consumes the deferred go request
    a_r6_go_clears: assert property (@(posedge clk) disable iff (rst)
        (start_fire && !go_set) |=> !go_q);

endmodule

// File: rtl/irtx_frame_seq.sv
module irtx_frame_seq
    import irtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_tag_mode,
    input  logic              cfg_urun_off,
    input  logic [LEN_W-1:0]  len_cfg,
    input  logic              ser_ready,
    input  logic              fifo_empty,
    input  txent_t            fifo_head,
    input  logic              fifo_clr,
    input  logic              resume_rd,
    input  logic              start_ok,
    output logic              pop,
    output logic              start_fire,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              out_abort,
    output logic              out_stretch,
    output logic              frame_done
);
    seq_st_t          st;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] flen;
    logic [LEN_W-1:0] next_cnt;
    logic             clr_seen;
    logic             fin;

    assign pop        = (st == S_SEND) && ser_ready && !fifo_empty;
    assign start_fire = (st == S_IDLE) && start_ok;
    assign next_cnt   = cnt + 1'b1;
    assign fin        = is_final(cfg_tag_mode, fifo_head.tag, next_cnt, flen);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            cnt         <= '0;
            flen        <= '0;
            clr_seen    <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_last    <= 1'b0;
            out_abort   <= 1'b0;
            out_stretch <= 1'b0;
            frame_done  <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            out_last    <= 1'b0;
            out_abort   <= 1'b0;
            out_stretch <= 1'b0;
            frame_done  <= out_last | out_abort;
            case (st)
                S_IDLE: begin
                    if (start_fire) begin
                        st   <= S_SEND;
                        cnt  <= '0;
                        flen <= len_cfg;
                    end
                end
                S_SEND: begin
                    if (ser_ready) begin
                        if (!fifo_empty) begin
                            out_valid <= 1'b1;
                            out_data  <= fifo_head.data;
                            cnt       <= next_cnt;
                            if (fin) begin
                                out_last <= 1'b1;
                                st       <= S_IDLE;
                            end
                        end else if (cfg_urun_off) begin
                            out_stretch <= 1'b1;
                        end else begin
                            out_abort <= 1'b1;
                            clr_seen  <= 1'b0;
                            st        <= S_LOCK;
                        end
                    end
                end
                S_LOCK: begin
                    if (fifo_clr) begin
                        clr_seen <= 1'b1;
                    end else if (resume_rd && clr_seen) begin
                        clr_seen <= 1'b0;
                        st       <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R12: one kind of slot event per cycle
    a_r12_outputs_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_abort, out_stretch}));

    // R3: the frame end marker rides on a data byte
    a_r3_last_is_data: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R8: a locked transmitter emits neither data nor stretch slots
    a_r8_locked_silent: assert property (@(posedge clk) disable iff (rst)
        (st == S_LOCK) |-> (!out_valid && !out_stretch));

    // R11: every close is followed by the done pulse
    a_r11_done_follows: assert property (@(posedge clk) disable iff (rst)
        (out_last || out_abort) |=> frame_done);

endmodule

// File: rtl/irtx_frame_closer.sv
module irtx_frame_closer
    import irtx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_tag_mode,
    input  logic              cfg_deferred,
    input  logic              cfg_urun_off,
    input  logic              len_lo_we,
    input  logic              len_hi_we,
    input  logic [BYTE_W-1:0] len_byte,
    input  logic              eot_set,
    input  logic              go_set,
    input  logic              fifo_clr,
    input  logic              resume_rd,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ser_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              out_abort,
    output logic              out_stretch,
    output logic              frame_done
);
    localparam int HALF = LEN_W / 2;

    logic [LEN_W-1:0] len_reg;
    logic             f_empty, f_full, f_pop;
    logic             start_ok, start_fire, tag_bit;
    txent_t           f_head, f_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_reg <= '0;
        end else begin
            if (len_lo_we) len_reg[HALF-1:0]     <= len_byte;
            if (len_hi_we) len_reg[LEN_W-1:HALF] <= len_byte;
        end
    end

    assign f_in = '{tag: tag_bit, data: wr_data};

    irtx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (wr_en),
        .wdata (f_in),
        .pop   (f_pop),
        .rdata (f_head),
        .empty (f_empty),
        .full  (f_full)
    );

    irtx_host_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .cfg_deferred (cfg_deferred),
        .go_set       (go_set),
        .eot_set      (eot_set),
        .wr_en        (wr_en),
        .fifo_full    (f_full),
        .fifo_clr     (fifo_clr),
        .fifo_empty   (f_empty),
        .start_fire   (start_fire),
        .start_ok     (start_ok),
        .tag_bit      (tag_bit)
    );

    irtx_frame_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .cfg_tag_mode (cfg_tag_mode),
        .cfg_urun_off (cfg_urun_off),
        .len_cfg      (len_reg),
        .ser_ready    (ser_ready),
        .fifo_empty   (f_empty),
        .fifo_head    (f_head),
        .fifo_clr     (fifo_clr),
        .resume_rd    (resume_rd),
        .start_ok     (start_ok),
        .pop          (f_pop),
        .start_fire   (start_fire),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_last     (out_last),
        .out_abort    (out_abort),
        .out_stretch  (out_stretch),
        .frame_done   (frame_done)
    );

endmodule

// File: tb/sim_irtx_frame_closer.sv
`timescale 1ns/1ps
module sim_irtx_frame_closer;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_tag_mode, cfg_deferred, cfg_urun_off;
    logic       len_lo_we, len_hi_we;
    logic [7:0] len_byte;
    logic       eot_set, go_set, fifo_clr, resume_rd;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       ser_ready;
    logic       out_valid, out_last, out_abort, out_stretch, frame_done;
    logic [7:0] out_data;

    always #5 clk = ~clk;

    irtx_frame_closer u0 (
        .clk(clk), .rst(rst),
        .cfg_tag_mode(cfg_tag_mode), .cfg_deferred(cfg_deferred), .cfg_urun_off(cfg_urun_off),
        .len_lo_we(len_lo_we), .len_hi_we(len_hi_we), .len_byte(len_byte),
        .eot_set(eot_set), .go_set(go_set), .fifo_clr(fifo_clr), .resume_rd(resume_rd),
        .wr_en(wr_en), .wr_data(wr_data), .ser_ready(ser_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_abort(out_abort), .out_stretch(out_stretch), .frame_done(frame_done)
    );

    // ---------------- monitor (cumulative) ----------------
    logic [7:0] cap [0:1023];
    int ncap = 0, last_n = 0, last_pos = -1, abort_n = 0, stretch_n = 0, done_n = 0, multi_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (out_last) begin
                    last_n   = last_n + 1;
                    last_pos = ncap;
                end
                cap[ncap & 1023] = out_data;
                ncap = ncap + 1;
            end
            if (out_abort)   abort_n   = abort_n + 1;
            if (out_stretch) stretch_n = stretch_n + 1;
            if (frame_done)  done_n    = done_n + 1;
            if ((int'(out_valid) + int'(out_abort) + int'(out_stretch)) > 1) multi_n = multi_n + 1;
        end
    end

    int s_cap, s_last, s_abort, s_stretch, s_done;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic snap();
        s_cap = ncap; s_last = last_n; s_abort = abort_n;
        s_stretch = stretch_n; s_done = done_n;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_go();     go_set = 1'b1;    tick(1); go_set = 1'b0;    endtask
    task automatic pulse_eot();    eot_set = 1'b1;   tick(1); eot_set = 1'b0;   endtask
    task automatic pulse_clr();    fifo_clr = 1'b1;  tick(1); fifo_clr = 1'b0;  endtask
    task automatic pulse_resume(); resume_rd = 1'b1; tick(1); resume_rd = 1'b0; endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; tick(1); wr_en = 1'b0;
    endtask

    task automatic set_len(input logic [15:0] l);
        len_byte = l[7:0];  len_lo_we = 1'b1; tick(1); len_lo_we = 1'b0;
        len_byte = l[15:8]; len_hi_we = 1'b1; tick(1); len_hi_we = 1'b0;
    endtask

    // compare n captured bytes starting at s_cap with base+i
    function automatic int data_errs(input int n, input logic [7:0] base);
        int e = 0;
        for (int i = 0; i < n; i++)
            if (cap[(s_cap + i) & 1023] !== 8'(base + i)) e++;
        return e;
    endfunction

    // ---------------- vector table ----------------
    typedef struct packed {
        logic        tagm;
        logic [15:0] len;
        logic [7:0]  nb;
        logic [7:0]  tagidx;
        logic [7:0]  base;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'd3, 8'd3, 8'd0, 8'h10},
        '{1'b0, 16'd1, 8'd1, 8'd0, 8'h20},
        '{1'b1, 16'd2, 8'd5, 8'd4, 8'h30},
        '{1'b1, 16'd9, 8'd1, 8'd0, 8'h40},
        '{1'b0, 16'd7, 8'd7, 8'd0, 8'h50}
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        rst = 1'b1;
        cfg_tag_mode = 1'b0; cfg_deferred = 1'b0; cfg_urun_off = 1'b0;
        len_lo_we = 1'b0; len_hi_we = 1'b0; len_byte = '0;
        eot_set = 1'b0; go_set = 1'b0; fifo_clr = 1'b0; resume_rd = 1'b0;
        wr_en = 1'b0; wr_data = '0; ser_ready = 1'b0;
        tick(3);
        rst = 1'b0;

        // R1: reset state
        check(out_valid === 1'b0,   "R1 out_valid",   int'(out_valid),   0);
        check(out_abort === 1'b0,   "R1 out_abort",   int'(out_abort),   0);
        check(out_stretch === 1'b0, "R1 out_stretch", int'(out_stretch), 0);
        check(frame_done === 1'b0,  "R1 frame_done",  int'(frame_done),  0);

        // table: R2 length frames, R4 tag frames, R3 last placement, R11 done
        for (int v = 0; v < NV; v++) begin
            ser_ready    = 1'b0;
            cfg_tag_mode = VEC[v].tagm;
            set_len(VEC[v].len);
            snap();
            for (int i = 0; i < int'(VEC[v].nb); i++) begin
                if (VEC[v].tagm && i == int'(VEC[v].tagidx)) pulse_eot();
                wr(8'(VEC[v].base + i));
            end
            ser_ready = 1'b1;
            tick(12 + int'(VEC[v].nb));
            check(ncap - s_cap == int'(VEC[v].nb), VEC[v].tagm ? "R4 byte count" : "R2 byte count",
                  ncap - s_cap, int'(VEC[v].nb));
            check(data_errs(int'(VEC[v].nb), VEC[v].base) == 0, "R10 data order",
                  data_errs(int'(VEC[v].nb), VEC[v].base), 0);
            check(last_n - s_last == 1 && last_pos - s_cap == int'(VEC[v].nb) - 1, "R3 last position",
                  last_pos - s_cap, int'(VEC[v].nb) - 1);
            check(done_n - s_done == 1, "R11 done pulse", done_n - s_done, 1);
            check(abort_n - s_abort == 0, "R7 no abort on full frame", abort_n - s_abort, 0);
        end
        ser_ready = 1'b0;
        cfg_tag_mode = 1'b0;

        // R2: high length byte used (260 bytes streamed)
        set_len(16'd260);
        snap();
        for (int i = 0; i < 60; i++) wr(8'(i));
        ser_ready = 1'b1;
        for (int i = 60; i < 260; i++) wr(8'(i));
        tick(80);
        check(ncap - s_cap == 260, "R2 long frame count", ncap - s_cap, 260);
        check(last_pos - s_cap == 259, "R2 long frame end", last_pos - s_cap, 259);
        check(data_errs(260, 8'h00) == 0, "R2 long frame data", data_errs(260, 8'h00), 0);
        check(abort_n - s_abort == 0, "R2 long frame no abort", abort_n - s_abort, 0);

        // R6: deferred start
        cfg_deferred = 1'b1;
        set_len(16'd2);
        snap();
        wr(8'h61); wr(8'h62);
        tick(10);
        check(ncap - s_cap == 0, "R6 held before go", ncap - s_cap, 0);
        pulse_go();
        tick(10);
        check(ncap - s_cap == 2 && cap[s_cap & 1023] == 8'h61, "R6 sent after go", ncap - s_cap, 2);
        snap();
        wr(8'h63); wr(8'h64);
        tick(10);
        check(ncap - s_cap == 0, "R6 go self-cleared", ncap - s_cap, 0);
        pulse_go();
        tick(10);
        check(ncap - s_cap == 2 && last_n - s_last == 1, "R6 second go", ncap - s_cap, 2);
        cfg_deferred = 1'b0;

        // R7/R8: underrun abort and lockout
        ser_ready = 1'b0;
        set_len(16'd5);
        snap();
        wr(8'hA0); wr(8'hA1);
        ser_ready = 1'b1;
        tick(10);
        check(ncap - s_cap == 2, "R7 bytes before underrun", ncap - s_cap, 2);
        check(abort_n - s_abort == 1, "R7 abort pulse", abort_n - s_abort, 1);
        check(last_n - s_last == 0, "R7 no good end", last_n - s_last, 0);
        check(done_n - s_done == 1, "R11 done after abort", done_n - s_done, 1);
        set_len(16'd2);
        snap();
        wr(8'hB0); wr(8'hB1);
        tick(10);
        check(ncap - s_cap == 0, "R8 locked no data", ncap - s_cap, 0);
        pulse_resume();
        tick(10);
        check(ncap - s_cap == 0, "R8 resume alone ignored", ncap - s_cap, 0);
        pulse_clr();
        pulse_resume();
        wr(8'hC0); wr(8'hC1);
        tick(10);
        check(ncap - s_cap == 2, "R8 unlocked count", ncap - s_cap, 2);
        check(cap[s_cap & 1023] == 8'hC0, "R8 flushed old bytes", int'(cap[s_cap & 1023]), 'hC0);
        check(abort_n - s_abort == 0, "R8 unlocked no abort", abort_n - s_abort, 0);

        // R9: stop-bit stretching with underrun handling off
        cfg_urun_off = 1'b1;
        ser_ready = 1'b0;
        set_len(16'd3);
        snap();
        wr(8'hD0);
        ser_ready = 1'b1;
        tick(6);
        check(stretch_n - s_stretch > 0, "R9 stretch seen", stretch_n - s_stretch, 1);
        check(abort_n - s_abort == 0, "R9 no abort", abort_n - s_abort, 0);
        wr(8'hD1); wr(8'hD2);
        tick(6);
        check(ncap - s_cap == 3 && last_pos - s_cap == 2, "R9 frame completes", ncap - s_cap, 3);
        check(data_errs(3, 8'hD0) == 0, "R9 data", data_errs(3, 8'hD0), 0);
        cfg_urun_off = 1'b0;

        // R10: full queue ignores writes
        ser_ready = 1'b0;
        set_len(16'd64);
        snap();
        for (int i = 0; i < 70; i++) wr(8'(i));
        ser_ready = 1'b1;
        tick(80);
        check(ncap - s_cap == 64, "R10 full count", ncap - s_cap, 64);
        check(data_errs(64, 8'h00) == 0, "R10 full data", data_errs(64, 8'h00), 0);
        check(last_pos - s_cap == 63 && abort_n - s_abort == 0, "R10 full end", last_pos - s_cap, 63);

        // R5: marker tags a single byte
        ser_ready = 1'b0;
        cfg_tag_mode = 1'b1;
        snap();
        pulse_eot();
        wr(8'hE0); wr(8'hE1);
        pulse_eot();
        wr(8'hE2);
        ser_ready = 1'b1;
        tick(12);
        check(ncap - s_cap == 3, "R5 byte count", ncap - s_cap, 3);
        check(last_n - s_last == 2, "R5 two frames", last_n - s_last, 2);
        check(last_pos - s_cap == 2, "R5 second frame end", last_pos - s_cap, 2);
        check(abort_n - s_abort == 0, "R5 no abort", abort_n - s_abort, 0);
        check(done_n - s_done == 2, "R11 two done pulses", done_n - s_done, 2);

        // R12: never two slot events at once
        check(multi_n == 0, "R12 exclusive outputs", multi_n, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule